// File: doc/BRIEF.md
# Region to Page Mapping Splitter

This block turns one memory region into a sequence of page mapping commands for a translation table writer. A request gives a virtual base, a physical base and a byte count. The block first widens the region so that it starts and ends on 4 KB boundaries. It then walks the region from low to high addresses and emits one command per page. Each command carries a virtual address, a physical address and a page-size code.

At every step the block uses the largest page the current virtual address allows, choosing from 16 MB, 1 MB, 64 KB and 4 KB, provided the page does not run past the end of the region. The physical address advances by the same amount. It is not checked for alignment.

The block ends the walk in one of three ways. A one-cycle completion pulse means the whole region was issued. An alignment error means no allowed page fits. A write error means the downstream writer rejected a command. A build can drop the smaller page sizes, which makes the alignment error reachable.

Top module: `region_page_splitter`

## Requirements
- R1: On acceptance, the low 12 bits of the virtual base are added to the byte count. The low 12 bits of both bases are then discarded, so the first command starts at the virtual base and at the physical base, each rounded down to a 4 KB boundary.
- R2: The adjusted byte count is rounded up to the next multiple of 4 KB. The count is computed one bit wider than `req_size`, so a region of 0xFFFFFFFF bytes at virtual base 0 yields exactly 4 GB of pages.
- R3: Page-size codes are 0 = 4 KB, 1 = 64 KB, 2 = 1 MB, 3 = 16 MB. Each command uses the largest enabled size that is no larger than the bytes still to issue and to which the current virtual address is aligned.
- R4: Only the virtual address is tested for alignment. The physical address of each command is the previous physical address plus the previous page size, whatever its alignment.
- R5: After every accepted command, the remaining count drops by the page size. When the count reaches zero, `done` is high for exactly one cycle with no command pending. `req_ready` is high only while no region is being processed. At most one of the three ending outputs is high in any cycle.
- R6: With `MIN_PAGE_CODE` set above 0, smaller page sizes are never used. If no enabled size fits at a step, `err_align` pulses for one cycle, no command is issued for that step, and the block returns to idle.
- R7: A region whose adjusted count is zero (zero bytes at a 4 KB aligned base) issues no command and pulses `done`.
- R8: If `wr_fail` is high in the cycle a command is accepted, `err_write` pulses in that cycle and no further command of that region is issued.
- R9: While `cmd_valid` is high and `cmd_ready` is low, the command fields and `cmd_valid` hold their values into the next cycle.
- R10: After reset the block is idle: `req_ready` is 1 and `cmd_valid`, `done`, `err_align` and `err_write` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A region request is offered |
| req_ready | output | 1 | The block is idle and will take a request |
| req_vbase | input | ADDR_W | Virtual base address of the region |
| req_pbase | input | ADDR_W | Physical base address of the region |
| req_size | input | SIZE_W | Region length in bytes |
| cmd_valid | output | 1 | A page command is offered |
| cmd_ready | input | 1 | The writer takes the command |
| cmd_vaddr | output | ADDR_W | Virtual address of the page |
| cmd_paddr | output | ADDR_W | Physical address of the page |
| cmd_pgsz | output | 2 | Page-size code (0 4 KB, 1 64 KB, 2 1 MB, 3 16 MB) |
| wr_fail | input | 1 | The writer rejects the command accepted this cycle |
| done | output | 1 | One-cycle pulse: whole region issued |
| err_align | output | 1 | One-cycle pulse: no enabled page fits |
| err_write | output | 1 | One-cycle pulse: walk aborted by writer failure |

## Verification
The hardest state to reach is the alignment error. With every page size enabled, the pre-adjustment always leaves a 4 KB step available, so the ports cannot reach that state. The bench therefore builds a second instance with 4 KB pages disabled and gives it one region too small for a 64 KB page and one region that leaves a 4 KB tail after a 64 KB page. Writer failure in the middle of a region is reached by raising `wr_fail` exactly in the cycle the second command is accepted. Hold behaviour is exercised by running a long, mixed-size region against a pseudo-random `cmd_ready` pattern.

// File: rtl/rps_pkg.sv
// Shared constants and types for the region to page splitter.
// Assumes a fixed 4 KB base granule; larger pages are 16x steps of it.
package rps_pkg;
    localparam int PG_LSB = 12;   // log2 of the base granule
    localparam int NUM_PG = 4;    // number of page sizes offered
    localparam int PG_STEP = 4;   // log2 ratio between neighbouring sizes

    typedef enum logic [1:0] {
        PG_4K  = 2'd0,
        PG_64K = 2'd1,
        PG_1M  = 2'd2,
        PG_16M = 2'd3
    } pg_code_e;
endpackage

// File: rtl/rps_prep.sv
// Request pre-adjustment: folds the virtual in-page offset into the length,
// rounds the length up to whole granules and drops the in-page address bits.
// Assumes SIZE_W > PG_LSB and ADDR_W > PG_LSB. Purely combinational.
module rps_prep
    import rps_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 32
) (
    input  logic [ADDR_W-1:0]          vbase,
    input  logic [ADDR_W-1:0]          pbase,
    input  logic [SIZE_W-1:0]          size,
    output logic [ADDR_W-PG_LSB-1:0]   vpage,
    output logic [ADDR_W-PG_LSB-1:0]   ppage,
    output logic [SIZE_W-PG_LSB:0]     pages
);
    localparam int SUM_W = SIZE_W + 1;

    logic [SUM_W-1:0] sum;
    logic             unused_plow;

    // Length plus virtual offset plus (granule-1), one bit wider to avoid wrap.
    assign sum = {1'b0, size}
               + SUM_W'(vbase[PG_LSB-1:0])
               + SUM_W'((1 << PG_LSB) - 1);

    // Granule count and page-aligned bases.
    assign pages       = sum[SUM_W-1:PG_LSB];
    assign vpage       = vbase[ADDR_W-1:PG_LSB];
    assign ppage       = pbase[ADDR_W-1:PG_LSB];
    assign unused_plow = ^pbase[PG_LSB-1:0];
endmodule

// File: rtl/rps_pick.sv
// Page-size selector: among the enabled sizes, finds the largest one that
// fits in the remaining granules and to which the virtual page is aligned.
// Assumes VP_W >= PG_STEP*(NUM_PG-1). Purely combinational.
module rps_pick
    import rps_pkg::*;
#(
    parameter int VP_W          = 20,
    parameter int RP_W          = 21,
    parameter int MIN_PAGE_CODE = 0
) (
    input  logic [VP_W-1:0] vpage,
    input  logic [RP_W-1:0] rem,
    output logic            fit,
    output pg_code_e        code,
    output logic [RP_W-1:0] step
);
    logic [NUM_PG-1:0] ok;

    for (genvar g = 0; g < NUM_PG; g++) begin : g_cand
        localparam int SH = g * PG_STEP;
        logic aligned;
        // Alignment test of the virtual page for this candidate size.
        if (SH == 0) begin : g_base
            assign aligned = 1'b1;
        end else begin : g_big
            assign aligned = (vpage[SH-1:0] == '0);
        end
        // Candidate is legal when enabled, aligned and not past the end.
        if (g < MIN_PAGE_CODE) begin : g_off
            assign ok[g] = 1'b0;
        end else begin : g_on
            assign ok[g] = aligned && (rem >= (RP_W'(1) << SH));
        end
    end

    // Priority: the highest legal code wins.
    always_comb begin
        fit  = 1'b0;
        code = PG_4K;
        for (int c = 0; c < NUM_PG; c++) begin
            if (ok[c]) begin
                fit  = 1'b1;
                code = pg_code_e'(c);
            end
        end
    end

    // Granule count of the chosen page.
    assign step = RP_W'(1) << {code, 2'b00};
endmodule

// File: rtl/rps_ctrl.sv
// Walk controller: holds the current virtual/physical page and remaining
// granules, offers one command per step and ends on completion, on an
// alignment miss or on a writer failure. Assumes the picker is combinational.
module rps_ctrl
    import rps_pkg::*;
#(
    parameter int VP_W = 20,
    parameter int RP_W = 21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VP_W-1:0] ld_vpage,
    input  logic [VP_W-1:0] ld_ppage,
    input  logic [RP_W-1:0] ld_pages,
    input  logic            fit,
    input  pg_code_e        code,
    input  logic [RP_W-1:0] step,
    output logic [VP_W-1:0] cur_vpage,
    output logic [VP_W-1:0] cur_ppage,
    output logic [RP_W-1:0] cur_rem,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    input  logic            wr_fail,
    output logic            done,
    output logic            err_align,
    output logic            err_write
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    st_e  state;
    logic running;
    logic accept;
    logic finish;

    // Handshake and ending conditions derived from state and picker result.
    assign running   = (state == S_RUN);
    assign req_ready = (state == S_IDLE);
    assign done      = running && (cur_rem == '0);
    assign err_align = running && (cur_rem != '0) && !fit;
    assign cmd_valid = running && (cur_rem != '0) && fit;
    assign accept    = cmd_valid && cmd_ready;
    assign err_write = accept && wr_fail;
    assign finish    = done || err_align || err_write;

    // State register: idle until a request, running until an ending event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else if (state == S_IDLE) begin
            if (req_valid) state <= S_RUN;
        end else if (finish) begin
            state <= S_IDLE;
        end
    end

    // Walk registers: load on request, advance by one page per accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vpage <= '0;
            cur_ppage <= '0;
            cur_rem   <= '0;
        end else if (state == S_IDLE && req_valid) begin
            cur_vpage <= ld_vpage;
            cur_ppage <= ld_ppage;
            cur_rem   <= ld_pages;
        end else if (accept && !wr_fail) begin
            cur_vpage <= cur_vpage + VP_W'(step);
            cur_ppage <= cur_ppage + VP_W'(step);
            cur_rem   <= cur_rem - step;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cur_vpage) && $stable(cur_ppage) && $stable(code)));  // R9
    AST_PAGE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (step <= cur_rem));  // R3
    AST_PAGE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ((cur_vpage & (VP_W'(step) - VP_W'(1))) == '0));  // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R5
    AST_ONE_ENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err_align, err_write}));  // R5
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);  // R5
    AST_ALIGN_NOCMD: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |=> (req_ready && !cmd_valid));  // R6
    AST_WRITE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        err_write |=> (req_ready && !cmd_valid));  // R8
endmodule

// File: rtl/region_page_splitter.sv
// Top level: splits a virtual/physical region into page mapping commands.
// Each step takes one cycle when the writer is ready; the command stream is
// backpressured by cmd_ready. Assumes ADDR_W >= 24 so 16 MB pages exist.
module region_page_splitter
    import rps_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 32,
    parameter int MIN_PAGE_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vbase,
    input  logic [ADDR_W-1:0] req_pbase,
    input  logic [SIZE_W-1:0] req_size,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_vaddr,
    output logic [ADDR_W-1:0] cmd_paddr,
    output logic [1:0]        cmd_pgsz,
    input  logic              wr_fail,
    output logic              done,
    output logic              err_align,
    output logic              err_write
);
    localparam int VP_W = ADDR_W - PG_LSB;
    localparam int RP_W = SIZE_W + 1 - PG_LSB;

    logic [VP_W-1:0] ld_vpage, ld_ppage, cur_vpage, cur_ppage;
    logic [RP_W-1:0] ld_pages, cur_rem, step;
    logic            fit;
    pg_code_e        code;

    rps_prep #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_prep (
        .vbase (req_vbase),
        .pbase (req_pbase),
        .size  (req_size),
        .vpage (ld_vpage),
        .ppage (ld_ppage),
        .pages (ld_pages)
    );

    rps_pick #(.VP_W(VP_W), .RP_W(RP_W), .MIN_PAGE_CODE(MIN_PAGE_CODE)) u_pick (
        .vpage (cur_vpage),
        .rem   (cur_rem),
        .fit   (fit),
        .code  (code),
        .step  (step)
    );

    rps_ctrl #(.VP_W(VP_W), .RP_W(RP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .ld_vpage  (ld_vpage),
        .ld_ppage  (ld_ppage),
        .ld_pages  (ld_pages),
        .fit       (fit),
        .code      (code),
        .step      (step),
        .cur_vpage (cur_vpage),
        .cur_ppage (cur_ppage),
        .cur_rem   (cur_rem),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .wr_fail   (wr_fail),
        .done      (done),
        .err_align (err_align),
        .err_write (err_write)
    );

    // Command fields: page numbers widened back to byte addresses.
    assign cmd_vaddr = {cur_vpage, {PG_LSB{1'b0}}};
    assign cmd_paddr = {cur_ppage, {PG_LSB{1'b0}}};
    assign cmd_pgsz  = code;
endmodule

// File: tb/sim_region_page_splitter.sv
module sim_region_page_splitter;
    typedef struct packed {
        logic [31:0] v;
        logic [31:0] p;
        logic [1:0]  c;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] req_vbase = '0, req_pbase = '0, req_size = '0;
    logic cmd_ready = 1'b1;
    logic wr_fail;
    logic sel = 1'b0;

    logic r0, v0, d0, ea0, ew0, r1, v1, d1, ea1, ew1;
    logic [31:0] va0, pa0, va1, pa1;
    logic [1:0] ps0, ps1;

    always #5 clk = ~clk;

    region_page_splitter u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r0),
        .req_vbase(req_vbase), .req_pbase(req_pbase), .req_size(req_size),
        .cmd_valid(v0), .cmd_ready(cmd_ready), .cmd_vaddr(va0), .cmd_paddr(pa0),
        .cmd_pgsz(ps0), .wr_fail(wr_fail), .done(d0), .err_align(ea0), .err_write(ew0));

    region_page_splitter #(.MIN_PAGE_CODE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(r1),
        .req_vbase(req_vbase), .req_pbase(req_pbase), .req_size(req_size),
        .cmd_valid(v1), .cmd_ready(cmd_ready), .cmd_vaddr(va1), .cmd_paddr(pa1),
        .cmd_pgsz(ps1), .wr_fail(wr_fail), .done(d1), .err_align(ea1), .err_write(ew1));

    wire        m_ready = sel ? r1 : r0;
    wire        m_valid = sel ? v1 : v0;
    wire [31:0] m_va    = sel ? va1 : va0;
    wire [31:0] m_pa    = sel ? pa1 : pa0;
    wire [1:0]  m_ps    = sel ? ps1 : ps0;
    wire        m_done  = sel ? d1 : d0;
    wire        m_ea    = sel ? ea1 : ea0;
    wire        m_ew    = sel ? ew1 : ew0;

    int checks = 0;
    int errors = 0;
    exp_t expq[$];
    int exp_term = 0;          // 0 done, 1 alignment error, 2 write error
    bit term_seen = 1'b0;
    string cur_tag = "R3";
    int acc_cnt = 0;
    int fail_idx = 0;
    bit fail_en = 1'b0;
    bit pend_acc = 1'b0;
    bit stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;
    bit prev_stall = 1'b0;
    logic [31:0] hold_va, hold_pa;
    logic [1:0] hold_ps;
    int cycles = 0;

    assign wr_fail = fail_en && (acc_cnt == fail_idx);

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Expected page list computed from the requirements.
    task automatic build_exp(input longint v, input longint p, input longint sz,
                             input int minc, input int fidx);
        longint total, va, pa, unit;
        int idx, found;
        total = sz + (v % 4096);
        total = ((total + 4095) / 4096) * 4096;
        va = v - (v % 4096);
        pa = p - (p % 4096);
        idx = 0;
        exp_term = 0;
        while (total != 0) begin
            exp_t e;
            found = -1;
            for (int c = 3; c >= minc; c--) begin
                unit = longint'(4096) << (4 * c);
                if (found < 0 && unit <= total && (va % unit) == 0) found = c;
            end
            if (found < 0) begin
                exp_term = 1;
                return;
            end
            unit = longint'(4096) << (4 * found);
            e.v = va[31:0];
            e.p = pa[31:0];
            e.c = found[1:0];
            expq.push_back(e);
            if (idx == fidx) begin
                exp_term = 2;
                return;
            end
            total -= unit;
            va += unit;
            pa += unit;
            idx++;
        end
    endtask

    // Driver: builds expectations, then hands one region to the selected instance.
    task automatic run_case(input bit which, input longint v, input longint p,
                            input longint sz, input int fidx, input string tag);
        @(posedge clk);
        #2;
        sel = which;
        cur_tag = tag;
        expq.delete();
        build_exp(v, p, sz, which ? 1 : 0, fidx);
        acc_cnt = 0;
        fail_idx = fidx;
        fail_en = (fidx >= 0);
        term_seen = 1'b0;
        req_vbase = v[31:0];
        req_pbase = p[31:0];
        req_size = sz[31:0];
        req_valid = 1'b1;
        @(posedge clk);
        #2;
        req_valid = 1'b0;
        wait (term_seen);
        @(posedge clk);
        #2;
        fail_en = 1'b0;
    endtask

    // Writer readiness pattern.
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cmd_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    // Accepted-command counter, updated just after the edge that took it.
    always @(posedge clk) begin
        #1;
        if (pend_acc) begin
            acc_cnt = acc_cnt + 1;
            pend_acc = 1'b0;
        end
    end

    // Monitor: scoreboard compare, hold check and ending check.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                chk(m_valid && m_va == hold_va && m_pa == hold_pa && m_ps == hold_ps,
                    "R9", "held command", {m_va, m_pa}, {hold_va, hold_pa});
            end
            if (m_valid && m_ready) chk(1'b0, "R5", "ready while busy", 1, 0);
            if (m_valid && cmd_ready) begin
                pend_acc = 1'b1;
                if (expq.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected command", m_va, 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(m_va == e.v, cur_tag, "vaddr", m_va, e.v);
                    chk(m_pa == e.p, cur_tag, "paddr", m_pa, e.p);
                    chk(m_ps == e.c, cur_tag, "page code", m_ps, e.c);
                end
            end
            if (m_done || m_ea || m_ew) begin
                int got;
                got = m_done ? 0 : (m_ea ? 1 : 2);
                chk(got == exp_term && !term_seen, cur_tag, "ending kind", got, exp_term);
                chk(expq.size() == 0, cur_tag, "commands left at end", expq.size(), 0);
                term_seen = 1'b1;
            end
            prev_stall = m_valid && !cmd_ready;
            hold_va = m_va;
            hold_pa = m_pa;
            hold_ps = m_ps;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #2;
        rst_n = 1'b1;
        @(negedge clk);
        // R10: idle after reset
        chk(r0 && !v0 && !d0 && !ea0 && !ew0, "R10", "reset state",
            {r0, v0, d0, ea0, ew0}, 5'b10000);
        // R3: one page of each size in descending order
        run_case(1'b0, 64'h0100_0000, 64'h8000_0000, 64'h0111_1000, -1, "R3");
        // R1: offset folded into length, both bases truncated
        run_case(1'b0, 64'h0000_0123, 64'h4000_0456, 64'h0000_1000, -1, "R1");
        // R1: zero bytes at an unaligned base still covers one page
        run_case(1'b0, 64'h0000_5010, 64'h0000_9000, 64'h0, -1, "R1");
        // R4: virtual alignment drives sizes, physical base unaligned to them
        run_case(1'b0, 64'h000F_0000, 64'h1234_5000, 64'h0020_0000, -1, "R4");
        // R7: empty region
        run_case(1'b0, 64'h0000_5000, 64'h0000_7000, 64'h0, -1, "R7");
        // R2: length rounding beyond the size width
        run_case(1'b0, 64'h0, 64'h8000_0000, 64'hFFFF_FFFF, -1, "R2");
        // R5: back-to-back regions with partial-granule length
        run_case(1'b0, 64'h0003_0000, 64'h0, 64'h0001_0001, -1, "R5");
        run_case(1'b0, 64'h0040_0800, 64'h0050_0000, 64'h0010_0000, -1, "R5");
        // R8: writer failure on the second command
        run_case(1'b0, 64'h0, 64'h0, 64'h3000, 1, "R8");
        // R8: failure on the first command of a large-page region
        run_case(1'b0, 64'h0200_0000, 64'h0300_0000, 64'h0200_0000, 0, "R8");
        // R9: backpressure on a mixed-size region
        stall_mode = 1'b1;
        run_case(1'b0, 64'h000F_0000, 64'h2000_0000, 64'h0020_0000, -1, "R9");
        run_case(1'b0, 64'h0100_0000, 64'h8000_0000, 64'h0111_1000, -1, "R9");
        stall_mode = 1'b0;
        // R6: smallest page disabled, alignment misses
        run_case(1'b1, 64'h0001_1000, 64'h0, 64'h0000_1000, -1, "R6");
        run_case(1'b1, 64'h0001_0000, 64'h2000_0000, 64'h0001_1000, -1, "R6");
        run_case(1'b1, 64'h0010_0000, 64'h0, 64'h0010_0000, -1, "R6");
        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule